// File: doc/BRIEF.md
# Clock-Rate Ratio Tracker with Read and Polyphase Index Outputs

This block sits between two unrelated sample clocks in a sample-rate converter. It measures how fast input samples arrive compared with output samples. For every output sample it names the group of stored input samples to use and the interpolation phase within that group. It does not compute any samples itself.

A 10-bit Gray-coded count advances once per input sample. Two registers carry it into the output clock domain, where it is decoded back to binary and widened to a 24-bit phase. A 24-bit phase accumulator, clocked by the output clock, tries to follow that phase. The wrapped, signed distance between the two phases is clipped. It then drives a loop filter whose output is the accumulator step. Once locked, that step equals 2^14 times the ratio of input rate to output rate. A magnitude comparator picks the filter gains on its own: coarse, fast gains while the error is large and gentle, low-noise gains once it is small.

The output clock must be faster than the input clock. The two resets are active low, asynchronous, and released together.

Top module: `ratio_pll`

## Requirements
- R1: The input-domain Gray count changes in exactly one bit on every input clock edge after reset.
- R2: After the two-register crossing and decoding, the converted input phase advances by either 0 or 2^14 per output cycle, provided the output clock is the faster clock.
- R3: The 14-bit value {read_idx, poly_idx} is the accumulator rounded to bits [23:10], with bit 9 as the rounding bit; a carry out of poly_idx increments read_idx. Per output cycle this value therefore advances, modulo 2^14, by floor(s/1024) or floor(s/1024)+1, where s is the inv_ratio value shown before that edge.
- R4: The phase error is clipped to magnitude 2^20 before filtering, so inv_ratio never moves by more than 2^17+2^10+2 in one output cycle.
- R5: fast_sel is 1 while the clipped error magnitude exceeds 2^15 and 0 otherwise. It shows 1 during acquisition from reset, and it is almost always 0 once locked.
- R6: Starting from a zero step, inv_ratio settles so that its average over 2048 output cycles is within 1% (plus 64) of 2^14·f_in/f_out.
- R7: Phase wrap of the count and the accumulator is treated as a small signed error. After lock, {read_idx, poly_idx} stays within 160 of 16 times the input-sample count, modulo 2^14, across many wraps.
- R8: While reset is held, read_idx, poly_idx, inv_ratio and fast_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Input sample clock |
| in_rst_n | input | 1 | Active-low asynchronous reset, input domain |
| out_clk | input | 1 | Output sample clock (the faster one) |
| out_rst_n | input | 1 | Active-low asynchronous reset, output domain |
| read_idx | output | 4 | Buffer group index for the current output sample |
| poly_idx | output | 10 | Interpolation phase index, rounded |
| inv_ratio | output | 24 | Accumulator step, 2^14·f_in/f_out when locked |
| fast_sel | output | 1 | 1 when the fast-acquisition gains are in use |

## Verification
Four properties are checked on every cycle:
- the single-bit change of the Gray count;
- the 0-or-one-count step of the converted phase;
- the bound that the clipper puts on each change of inv_ratio;
- the link between successive index values and the step in force before each edge.

Some behaviour only appears as a run unfolds. Acquisition that starts in the fast gains and ends in the slow ones, the accuracy of the settled ratio, and phase tracking across counter wraparound can only be shown by the bench. It does this for directed clock ratios, including one close to 1, and for randomly chosen ratios.

// File: rtl/ratio_pll.sv
`timescale 1ps/1ps
module ratio_pll #(
  parameter int CNT_W   = 10,
  parameter int PH_W    = 24,
  parameter int RD_W    = 4,
  parameter int POLY_W  = 10,
  parameter int LIM_LOG = 20,
  parameter int THR_LOG = 15,
  parameter int P_FAST  = 4,
  parameter int I_FAST  = 10,
  parameter int P_SLOW  = 6,
  parameter int I_SLOW  = 14
) (
  input  logic              in_clk,
  input  logic              in_rst_n,
  input  logic              out_clk,
  input  logic              out_rst_n,
  output logic [RD_W-1:0]   read_idx,
  output logic [POLY_W-1:0] poly_idx,
  output logic [PH_W-1:0]   inv_ratio,
  output logic              fast_sel
);
  localparam int IDX_W = RD_W + POLY_W;
  localparam int FW    = PH_W - IDX_W;
  localparam int SH    = PH_W - CNT_W;
  localparam int EW    = PH_W + 2;
  localparam logic signed [EW-1:0] LIM_P = EW'(2 ** LIM_LOG);
  localparam logic signed [EW-1:0] LIM_N = -LIM_P;
  localparam logic signed [EW-1:0] THR   = EW'(2 ** THR_LOG);
  localparam logic signed [EW-1:0] MAXI  = {2'b00, {PH_W{1'b1}}};

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // input domain: binary count with registered Gray image
  logic [CNT_W-1:0] bin_q, gray_q;
  wire  [CNT_W-1:0] bin_nx = bin_q + 1'b1;

  always_ff @(posedge in_clk or negedge in_rst_n)
    if (!in_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end

  // output domain
  logic [CNT_W-1:0] sync1_q, sync2_q;
  logic [PH_W-1:0]  acc_q, inc_q, inc_nx;
  logic signed [EW-1:0] e_prev_q, err_raw, err_lim, mag, step, inc_sum;

  wire [PH_W-1:0] in_phase = {gray2bin(sync2_q), {SH{1'b0}}};
  wire [PH_W-1:0] diff     = in_phase - acc_q;

  always_comb begin
    err_raw = {{(EW-PH_W){diff[PH_W-1]}}, diff};
    err_lim = (err_raw > LIM_P) ? LIM_P : (err_raw < LIM_N) ? LIM_N : err_raw;
    mag     = (err_lim < 0) ? -err_lim : err_lim;
    if (mag > THR)
      step = (err_lim >>> P_FAST) - (e_prev_q >>> P_FAST) + (err_lim >>> I_FAST);
    else
      step = (err_lim >>> P_SLOW) - (e_prev_q >>> P_SLOW) + (err_lim >>> I_SLOW);
    inc_sum = $signed({2'b00, inc_q}) + step;
    if (inc_sum < 0)         inc_nx = '0;
    else if (inc_sum > MAXI) inc_nx = MAXI[PH_W-1:0];
    else                     inc_nx = inc_sum[PH_W-1:0];
  end

  always_ff @(posedge out_clk or negedge out_rst_n)
    if (!out_rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      acc_q    <= '0;
      inc_q    <= '0;
      e_prev_q <= '0;
    end else begin
      sync1_q  <= gray_q;
      sync2_q  <= sync1_q;
      acc_q    <= acc_q + inc_q;
      inc_q    <= inc_nx;
      e_prev_q <= err_lim;
    end

  wire [IDX_W-1:0] rp = acc_q[PH_W-1:FW] + IDX_W'(acc_q[FW-1]);

  assign {read_idx, poly_idx} = rp;
  assign inv_ratio = inc_q;
  assign fast_sel  = (mag > THR);
endmodule

// File: rtl/ratio_pll_chk.sv
`timescale 1ps/1ps
module ratio_pll_chk #(
  parameter int CNT_W   = 10,
  parameter int PH_W    = 24,
  parameter int RD_W    = 4,
  parameter int POLY_W  = 10,
  parameter int LIM_LOG = 20,
  parameter int P_FAST  = 4,
  parameter int I_FAST  = 10
) (
  input logic              in_clk,
  input logic              in_rst_n,
  input logic              out_clk,
  input logic              out_rst_n,
  input logic [CNT_W-1:0]  gray_q,
  input logic [PH_W-1:0]   in_phase,
  input logic [RD_W-1:0]   read_idx,
  input logic [POLY_W-1:0] poly_idx,
  input logic [PH_W-1:0]   inv_ratio
);
  localparam int IDX_W = RD_W + POLY_W;
  localparam int FW    = PH_W - IDX_W;
  localparam logic [PH_W-1:0] STEP = PH_W'(1) << (PH_W - CNT_W);
  localparam logic signed [PH_W+1:0] BOUND =
    (PH_W+2)'(2 ** (LIM_LOG - P_FAST + 1) + 2 ** (LIM_LOG - I_FAST) + 2);

  wire [IDX_W-1:0] rp = {read_idx, poly_idx};
  wire [IDX_W-1:0] q  = inv_ratio[PH_W-1:FW];
  wire signed [PH_W+1:0] inc_s = $signed({2'b00, inv_ratio});

  AST_GRAY_ONE_BIT: assert property (@(posedge in_clk) disable iff (!in_rst_n)
    $past(in_rst_n) |-> $countones(gray_q ^ $past(gray_q)) == 1); // R1

  AST_PHASE_STEP: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    ($past(out_rst_n) && $past(out_rst_n, 2)) |->
      (in_phase == $past(in_phase)) || (in_phase == $past(in_phase) + STEP)); // R2

  AST_INC_STEP_BOUND: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    $past(out_rst_n) |->
      ((inc_s - $past(inc_s)) <= BOUND) && ((inc_s - $past(inc_s)) >= -BOUND)); // R4

  AST_IDX_ADVANCE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    $past(out_rst_n) |->
      (rp == IDX_W'($past(rp) + $past(q))) ||
      (rp == IDX_W'($past(rp) + $past(q) + 1'b1))); // R3
endmodule

bind ratio_pll ratio_pll_chk #(
  .CNT_W(CNT_W), .PH_W(PH_W), .RD_W(RD_W), .POLY_W(POLY_W),
  .LIM_LOG(LIM_LOG), .P_FAST(P_FAST), .I_FAST(I_FAST)
) u_chk (
  .in_clk(in_clk), .in_rst_n(in_rst_n), .out_clk(out_clk), .out_rst_n(out_rst_n),
  .gray_q(gray_q), .in_phase(in_phase), .read_idx(read_idx),
  .poly_idx(poly_idx), .inv_ratio(inv_ratio)
);

// File: tb/ratio_pll_bench.sv
`timescale 1ps/1ps
module ratio_pll_bench;
  logic in_clk = 1'b0, out_clk = 1'b0;
  logic in_rst_n = 1'b0, out_rst_n = 1'b0;
  logic [3:0]  read_idx;
  logic [9:0]  poly_idx;
  logic [23:0] inv_ratio;
  logic        fast_sel;
  int in_half_ps = 2600;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [9:0] in_cnt;

  ratio_pll u_ratio_pll (
    .in_clk(in_clk), .in_rst_n(in_rst_n), .out_clk(out_clk), .out_rst_n(out_rst_n),
    .read_idx(read_idx), .poly_idx(poly_idx), .inv_ratio(inv_ratio), .fast_sel(fast_sel)
  );

  initial forever begin #2000; out_clk = ~out_clk; end
  initial forever begin #(in_half_ps); in_clk = ~in_clk; end

  always @(posedge in_clk or negedge in_rst_n)
    if (!in_rst_n) in_cnt <= '0;
    else           in_cnt <= in_cnt + 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ratio(input int half_ps);
    return (longint'(16384) * 4000) / (2 * half_ps);
  endfunction

  function automatic bit idx_step_ok(input logic [13:0] prev, input logic [23:0] s,
                                     input logic [13:0] cur);
    logic [13:0] d = cur - prev;
    logic [13:0] f = s[23:10];
    return (d == f) || (d == f + 14'd1);
  endfunction

  function automatic bit inc_step_ok(input logic [23:0] prev, input logic [23:0] cur);
    longint d = longint'(cur) - longint'(prev);
    return (d <= 132098) && (d >= -132098);
  endfunction

  task automatic run(input int half_ps);
    logic [13:0] prev_rp, cur_rp;
    logic [23:0] prev_inc;
    logic signed [13:0] pd;
    int idx_bad = 0, inc_bad = 0, fast_cnt = 0, max_dev = 0;
    bit fast_seen = 1'b0;
    longint sum = 0, avg, ex;
    in_rst_n = 1'b0; out_rst_n = 1'b0;
    in_half_ps = half_ps;
    repeat (4) @(negedge out_clk);
    // R8 reset values
    chk({read_idx, poly_idx} == 14'd0, "R8 index in reset", {read_idx, poly_idx}, 0);
    chk(inv_ratio == 24'd0 && !fast_sel, "R8 ratio/mode in reset", inv_ratio, 0);
    in_rst_n = 1'b1; out_rst_n = 1'b1;
    @(negedge out_clk);
    prev_rp = {read_idx, poly_idx}; prev_inc = inv_ratio;
    for (int n = 0; n < 10048; n++) begin
      @(negedge out_clk);
      cur_rp = {read_idx, poly_idx};
      if (!idx_step_ok(prev_rp, prev_inc, cur_rp)) idx_bad++;
      if (!inc_step_ok(prev_inc, inv_ratio)) inc_bad++;
      if (n < 400 && fast_sel) fast_seen = 1'b1;
      if (n >= 8000) begin
        sum += inv_ratio;
        if (fast_sel) fast_cnt++;
        pd = $signed(14'({in_cnt, 4'b0000}) - cur_rp);
        if ((pd < 0 ? -int'(pd) : int'(pd)) > max_dev) max_dev = pd < 0 ? -int'(pd) : int'(pd);
      end
      prev_rp = cur_rp; prev_inc = inv_ratio;
    end
    ex  = exp_ratio(half_ps);
    avg = sum / 2048;
    chk(idx_bad == 0, "R3 index advance", idx_bad, 0);
    chk(inc_bad == 0, "R4 clipped step", inc_bad, 0);
    chk(fast_seen, "R5 fast gains during acquisition", fast_seen, 1);
    chk(fast_cnt <= 128, "R5 slow gains after lock", fast_cnt, 0);
    chk((avg - ex <= ex / 100 + 64) && (ex - avg <= ex / 100 + 64), "R6 settled ratio", avg, ex);
    chk(max_dev <= 160, "R1 R2 R7 phase tracking", max_dev, 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed);
    run(2600);
    run(4000);
    run(2050);
    for (int k = 0; k < 2; k++) begin
      r = $urandom;
      run(2200 + int'(r % 2500));
    end
    in_rst_n = 1'b0; out_rst_n = 1'b0;
    repeat (3) @(negedge out_clk);
    chk({read_idx, poly_idx, inv_ratio} == '0, "R8 final reset", inv_ratio, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule